// File: doc/BRIEF.md
# PCI Target Single-Read Latency Controller

This block is the bus-facing half of a 32-bit PCI target that serves a single-word memory read while the bus waits. It watches for an address phase that carries the memory-read command and an address inside its decode window. It claims the cycle by asserting DEVSEL# and sends a one-clock request pulse to the local side. It then holds TRDY# high, inserting wait states, until the local read FIFO reports that it holds a word.

When the word arrives within the selected bound of 16 or 32 wait clocks, the block pops it, drives it on AD and asserts TRDY# and STOP# together. This ends the transfer after one data phase. When the bound expires first, the block signals a retry instead. A mode input can turn the waiting off, and then every claimed read is retried at once. After either ending the block drives its three control lines high for one clock and then releases them.

Top module: `pci_rdlat_target`

## Requirements
- R1: While reset is held and on the first clock after it, all outputs are inactive: ctl_oe=0, ad_oe=0, req_o=0, fifo_rd=0, and devsel_n_o, trdy_n_o and stop_n_o are 1.
- R2: An address phase is a clock where frame_n is 0 after having been 1 on the previous clock. If that phase has cbe_n=4'b0110 (memory read), and ad_in[31:12] equals the base window, then on the next clock devsel_n_o=0, ctl_oe=1 and req_o=1, and req_o lasts exactly one clock.
- R3: An address phase with another command, or with an address outside the window, is not claimed: ctl_oe stays 0 and req_o stays 0.
- R4: With stall_en=1, a claimed read holds devsel_n_o=0, trdy_n_o=1 and stop_n_o=1 (a wait state) on every clock in which no word has yet been popped.
- R5: The largest number of wait states is 16 when lat_sel=0 and 32 when lat_sel=1. A word that becomes available on the last allowed wait state is still delivered.
- R6: On a wait-state clock with fifo_empty=0, fifo_rd is 1 for that clock. On the next clock trdy_n_o=0, stop_n_o=0, devsel_n_o=0 and ad_oe=1, and ad_out equals the fifo_data value that was present when the word was popped.
- R7: The completion drive (TRDY#, STOP# and AD all driven) holds unchanged for as long as irdy_n stays 1.
- R8: When the wait bound expires with no word, the block signals a retry: devsel_n_o=0, stop_n_o=0 and trdy_n_o=1. This holds for as long as frame_n stays 0.
- R9: With stall_en=0, a claimed read goes straight to retry on the first clock after the address phase, with no wait states.
- R10: On the clock after the data phase completes (irdy_n=0 during completion), or after frame_n is seen high during a retry, the block drives devsel_n_o, trdy_n_o and stop_n_o to 1 with ctl_oe=1 for one clock. On the clock after that ctl_oe=0.
- R11: The wait-state count restarts at zero for every new transaction, so a read that follows a timeout again gets the full bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_en | input | 1 | 1: hold the bus with wait states; 0: retry at once |
| lat_sel | input | 1 | Wait-state bound select: 0 gives 16, 1 gives 32 |
| frame_n | input | 1 | FRAME#, low while the master owns the cycle |
| irdy_n | input | 1 | IRDY#, master ready, low active |
| cbe_n | input | 4 | C/BE#: command in the address phase |
| ad_in | input | 32 | AD as seen on the bus (address in the address phase) |
| ad_out | output | 32 | Read word driven on AD |
| ad_oe | output | 1 | Enable for driving ad_out onto AD |
| devsel_n_o | output | 1 | DEVSEL# value |
| trdy_n_o | output | 1 | TRDY# value |
| stop_n_o | output | 1 | STOP# value |
| ctl_oe | output | 1 | Enable for driving DEVSEL#, TRDY# and STOP# |
| req_o | output | 1 | One-clock request pulse to the local side on claim |
| fifo_empty | input | 1 | Read FIFO holds no word |
| fifo_rd | output | 1 | Pop strobe for the read FIFO |
| fifo_data | input | 32 | Head word of the read FIFO |

## Verification
Reads are run with the FIFO word showing up after a few wait states, exactly on the last allowed wait state, and never. Together these separate an early completion, the off-by-one boundary of the bound and a timeout, under both bound settings. Separate patterns stretch the completion with a late IRDY# and stretch the retry with a late FRAME# release, which shows whether each ending holds until the master acts. Reads with the wrong command or an address outside the window, a read with waiting turned off, and a read issued right after a timeout separate the decode, the immediate-retry mode and the per-transaction restart of the count.

// File: rtl/pci_rdlat_pkg.sv
package pci_rdlat_pkg;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_DATA  = 3'd2,
        ST_RETRY = 3'd3,
        ST_TURN  = 3'd4
    } tgt_state_e;

    typedef struct packed {
        logic ctl_oe;
        logic devsel_n;
        logic trdy_n;
        logic stop_n;
        logic ad_oe;
    } bus_drive_t;

    function automatic bus_drive_t drive_for(tgt_state_e s);
        bus_drive_t d;
        d = '{ctl_oe: 1'b0, devsel_n: 1'b1, trdy_n: 1'b1, stop_n: 1'b1, ad_oe: 1'b0};
        case (s)
            ST_WAIT:  begin d.ctl_oe = 1'b1; d.devsel_n = 1'b0; end
            ST_DATA:  begin d.ctl_oe = 1'b1; d.devsel_n = 1'b0; d.trdy_n = 1'b0;
                            d.stop_n = 1'b0; d.ad_oe = 1'b1; end
            ST_RETRY: begin d.ctl_oe = 1'b1; d.devsel_n = 1'b0; d.stop_n = 1'b0; end
            ST_TURN:  begin d.ctl_oe = 1'b1; end
            default:  ;
        endcase
        return d;
    endfunction

    function automatic int last_wait(logic long_sel, int short_waits, int long_waits);
        return long_sel ? (long_waits - 1) : (short_waits - 1);
    endfunction

endpackage

// File: rtl/pci_rdlat_decode.sv
module pci_rdlat_decode
    import pci_rdlat_pkg::*;
#(
    parameter int              AD_W      = 32,
    parameter int              DEC_BITS  = 20,
    parameter logic [AD_W-1:0] BASE_ADDR = 32'h4000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            idle,
    input  logic            frame_n,
    input  logic [3:0]      cbe_n,
    input  logic [AD_W-1:0] ad_in,
    output logic            claim
);
    localparam int LSB = AD_W - DEC_BITS;

    logic frame_q;
    logic addr_phase;
    logic hit;
    logic unused_low;

    always_ff @(posedge clk) begin
        if (rst) frame_q <= 1'b1;
        else     frame_q <= frame_n;
    end

    assign addr_phase = frame_q && !frame_n;
    assign hit        = (ad_in[AD_W-1:LSB] == BASE_ADDR[AD_W-1:LSB]);
    assign claim      = idle && addr_phase && hit && (cbe_n == CMD_MEM_READ);
    assign unused_low = ^ad_in[LSB-1:0];

endmodule

// File: rtl/pci_rdlat_wait_cnt.sv
module pci_rdlat_wait_cnt
    import pci_rdlat_pkg::*;
#(
    parameter int SHORT_WAITS = 16,
    parameter int LONG_WAITS  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic long_sel,
    output logic expired
);
    localparam int CW = $clog2(LONG_WAITS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last_q;

    assign last_q = CW'(last_wait(long_sel, SHORT_WAITS, LONG_WAITS));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == last_q);

endmodule

// File: rtl/pci_rdlat_fsm.sv
module pci_rdlat_fsm
    import pci_rdlat_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            claim,
    input  logic            stall_en,
    input  logic            fifo_empty,
    input  logic [AD_W-1:0] fifo_data,
    input  logic            irdy_n,
    input  logic            frame_n,
    input  logic            expired,
    output tgt_state_e      state,
    output logic [AD_W-1:0] word_q
);
    tgt_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (claim) nxt = stall_en ? ST_WAIT : ST_RETRY;
            ST_WAIT:  begin
                if (!fifo_empty)  nxt = ST_DATA;
                else if (expired) nxt = ST_RETRY;
            end
            ST_DATA:  if (!irdy_n) nxt = ST_TURN;
            ST_RETRY: if (frame_n) nxt = ST_TURN;
            ST_TURN:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            word_q <= '0;
        end else begin
            state <= nxt;
            if (state == ST_WAIT && !fifo_empty) word_q <= fifo_data;
        end
    end

endmodule

// File: rtl/pci_rdlat_target.sv
module pci_rdlat_target
    import pci_rdlat_pkg::*;
#(
    parameter int          AD_W        = 32,
    parameter int          DEC_BITS    = 20,
    parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
    parameter int          SHORT_WAITS = 16,
    parameter int          LONG_WAITS  = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall_en,
    input  logic            lat_sel,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [3:0]      cbe_n,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] ad_out,
    output logic            ad_oe,
    output logic            devsel_n_o,
    output logic            trdy_n_o,
    output logic            stop_n_o,
    output logic            ctl_oe,
    output logic            req_o,
    input  logic            fifo_empty,
    output logic            fifo_rd,
    input  logic [AD_W-1:0] fifo_data
);
    tgt_state_e state;
    bus_drive_t drv;
    logic       claim;
    logic       expired;
    logic       in_wait;
    logic       req_q;

    assign in_wait = (state == ST_WAIT);

    pci_rdlat_decode #(
        .AD_W(AD_W), .DEC_BITS(DEC_BITS), .BASE_ADDR(AD_W'(BASE_ADDR))
    ) u_dec (
        .clk(clk), .rst(rst), .idle(state == ST_IDLE), .frame_n(frame_n),
        .cbe_n(cbe_n), .ad_in(ad_in), .claim(claim)
    );

    pci_rdlat_wait_cnt #(
        .SHORT_WAITS(SHORT_WAITS), .LONG_WAITS(LONG_WAITS)
    ) u_cnt (
        .clk(clk), .rst(rst), .clear(!in_wait), .step(in_wait && fifo_empty),
        .long_sel(lat_sel), .expired(expired)
    );

    pci_rdlat_fsm #(.AD_W(AD_W)) u_fsm (
        .clk(clk), .rst(rst), .claim(claim), .stall_en(stall_en),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .irdy_n(irdy_n),
        .frame_n(frame_n), .expired(expired), .state(state), .word_q(ad_out)
    );

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= claim;
    end

    assign drv        = drive_for(state);
    assign ctl_oe     = drv.ctl_oe;
    assign devsel_n_o = drv.devsel_n;
    assign trdy_n_o   = drv.trdy_n;
    assign stop_n_o   = drv.stop_n;
    assign ad_oe      = drv.ad_oe;
    assign req_o      = req_q;
    assign fifo_rd    = in_wait && !fifo_empty;

endmodule

// File: rtl/pci_rdlat_chk.sv
module pci_rdlat_chk #(
    parameter int LONG_WAITS = 32
) (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic ctl_oe,
    input logic devsel_n_o,
    input logic trdy_n_o,
    input logic stop_n_o,
    input logic ad_oe,
    input logic req_o,
    input logic fifo_rd
);
    localparam int WW = $clog2(LONG_WAITS + 2) + 1;

    logic [WW-1:0] wrun;
    logic          waiting;

    assign waiting = ctl_oe && !devsel_n_o && trdy_n_o && stop_n_o;

    always_ff @(posedge clk) begin
        if (rst)          wrun <= '0;
        else if (waiting) wrun <= wrun + 1'b1;
        else              wrun <= '0;
    end

    p_wait_bound_r5: assert property (@(posedge clk) disable iff (rst)
        wrun <= WW'(LONG_WAITS));

    p_req_single_r2: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !req_o);

    p_pop_then_data_r6: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> (!trdy_n_o && !stop_n_o && ad_oe));

    p_trdy_needs_claim_r6: assert property (@(posedge clk) disable iff (rst)
        !trdy_n_o |-> (!devsel_n_o && !stop_n_o && ad_oe && ctl_oe));

    p_retry_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && !stop_n_o && trdy_n_o && !frame_n) |=> (!stop_n_o && trdy_n_o && !devsel_n_o));

    p_turn_release_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_oe && devsel_n_o && trdy_n_o && stop_n_o) |=> !ctl_oe);

endmodule

bind pci_rdlat_target pci_rdlat_chk #(.LONG_WAITS(LONG_WAITS)) u_chk (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ctl_oe(ctl_oe),
    .devsel_n_o(devsel_n_o), .trdy_n_o(trdy_n_o), .stop_n_o(stop_n_o),
    .ad_oe(ad_oe), .req_o(req_o), .fifo_rd(fifo_rd)
);

// File: tb/sim_pci_rdlat_target.sv
module sim_pci_rdlat_target;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_en = 1'b1;
    logic        lat_sel = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n_o, trdy_n_o, stop_n_o, ctl_oe, req_o, fifo_rd;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_data = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pci_rdlat_target u0 (
        .clk(clk), .rst(rst), .stall_en(stall_en), .lat_sel(lat_sel),
        .frame_n(frame_n), .irdy_n(irdy_n), .cbe_n(cbe_n), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n_o(devsel_n_o),
        .trdy_n_o(trdy_n_o), .stop_n_o(stop_n_o), .ctl_oe(ctl_oe),
        .req_o(req_o), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
        .fifo_data(fifo_data)
    );

    task automatic check(input string tag, input bit ok, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 waiting, 2 completing, 3 retrying, 4 turnaround
    int          m_phase = 0;
    int          m_waited = 0;
    bit          m_prev_frame = 1;
    bit          m_req = 0;
    logic [31:0] m_word = '0;

    always @(posedge clk) begin
        bit addr_ph;
        bit hit;
        addr_ph = m_prev_frame && !frame_n;
        hit = addr_ph && (cbe_n == 4'b0110) && (ad_in[31:12] == 20'h40000) && (m_phase == 0);
        if (rst) begin
            m_phase = 0; m_waited = 0; m_prev_frame = 1; m_req = 0; m_word = '0;
        end else begin
            m_req = hit;
            case (m_phase)
                0: if (hit) begin m_phase = stall_en ? 1 : 3; m_waited = 0; end
                1: begin
                    m_waited++;
                    if (!fifo_empty) begin m_word = fifo_data; m_phase = 2; end
                    else if (m_waited >= (lat_sel ? 32 : 16)) m_phase = 3;
                end
                2: if (!irdy_n) m_phase = 4;
                3: if (frame_n) m_phase = 4;
                default: m_phase = 0;
            endcase
            m_prev_frame = frame_n;
        end
    end

    function automatic string phase_tag(int p);
        case (p)
            1: return "R4";
            2: return "R6";
            3: return "R8";
            4: return "R10";
            default: return "R3";
        endcase
    endfunction

    always @(negedge clk) begin
        #3;
        if (!rst && !done) begin
            bit e_oe, e_dev, e_trdy, e_stop, e_adoe, e_rd;
            e_oe   = (m_phase != 0);
            e_dev  = !(m_phase == 1 || m_phase == 2 || m_phase == 3);
            e_trdy = (m_phase != 2);
            e_stop = !(m_phase == 2 || m_phase == 3);
            e_adoe = (m_phase == 2);
            e_rd   = (m_phase == 1) && !fifo_empty;
            check(phase_tag(m_phase), {ctl_oe, devsel_n_o, trdy_n_o, stop_n_o, ad_oe, fifo_rd, req_o}
                  == {e_oe, e_dev, e_trdy, e_stop, e_adoe, e_rd, m_req}, "model outputs",
                  {ctl_oe, devsel_n_o, trdy_n_o, stop_n_o, ad_oe, fifo_rd, req_o},
                  {e_oe, e_dev, e_trdy, e_stop, e_adoe, e_rd, m_req});
            if (e_adoe) check("R6", ad_out == m_word, "model ad_out", ad_out, m_word);
        end
    end

    // results of the last transaction
    int          r_waits;
    int          r_outcome;   // 0 unclaimed, 1 data, 2 retry
    logic [31:0] r_word;
    bit          r_req1, r_dev1, r_req_any;

    task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr, input int d,
                           input logic [31:0] word, input int lag);
        bit fin;
        fin = 0; r_waits = 0; r_outcome = 0; r_word = '0; r_req_any = 0;
        @(negedge clk);
        frame_n = 0; cbe_n = cmd; ad_in = addr; irdy_n = 1;
        @(negedge clk);
        cbe_n = 4'h0; ad_in = '0; irdy_n = (lag == 0) ? 1'b0 : 1'b1;
        r_req1 = req_o; r_dev1 = !devsel_n_o;
        for (int i = 0; i < 80 && !fin; i++) begin
            if (req_o) r_req_any = 1;
            if (ctl_oe && !devsel_n_o && trdy_n_o && stop_n_o) begin
                r_waits++;
                if (d > 0 && r_waits == d) begin fifo_empty = 0; fifo_data = word; end
                @(negedge clk);
            end else if (!trdy_n_o) begin
                r_outcome = 1; r_word = ad_out; fifo_empty = 1; fin = 1;
                for (int k = 0; k < lag; k++) begin
                    @(negedge clk);
                    check("R7", !trdy_n_o && !stop_n_o && ad_oe && ad_out == word,
                          "completion held while IRDY# high", trdy_n_o, 0);
                end
                irdy_n = 0; frame_n = 1;
            end else if (!stop_n_o) begin
                r_outcome = 2; fin = 1;
                for (int k = 0; k < lag; k++) begin
                    @(negedge clk);
                    check("R8", !stop_n_o && trdy_n_o && !devsel_n_o,
                          "retry held while FRAME# low", stop_n_o, 0);
                end
                frame_n = 1; irdy_n = 0;
            end else if (i >= 8) begin
                fin = 1; frame_n = 1; irdy_n = 1;
            end else begin
                @(negedge clk);
            end
        end
        if (r_outcome != 0) begin
            @(negedge clk);
            check("R10", ctl_oe && devsel_n_o && trdy_n_o && stop_n_o && !ad_oe,
                  "turnaround drive", {ctl_oe, devsel_n_o, trdy_n_o, stop_n_o}, 4'hF);
            irdy_n = 1;
            @(negedge clk);
            check("R10", !ctl_oe, "release after turnaround", ctl_oe, 0);
        end
        @(negedge clk);
    endtask

    localparam logic [31:0] HIT  = 32'h4000_0010;
    localparam logic [31:0] MISS = 32'h5000_0010;

    initial begin
        repeat (3) @(negedge clk);
        check("R1", !ctl_oe && !ad_oe && !req_o && !fifo_rd && devsel_n_o && trdy_n_o && stop_n_o,
              "outputs during reset", {ctl_oe, ad_oe, req_o}, 0);
        rst = 0;
        @(negedge clk);
        check("R1", !ctl_oe && !ad_oe && !req_o && devsel_n_o && trdy_n_o && stop_n_o,
              "outputs after reset", {ctl_oe, ad_oe, req_o}, 0);

        run_txn(4'b0110, HIT, 3, 32'hA5A5_0001, 0);
        check("R2", r_req1 && r_dev1, "claim and request on next clock", {r_req1, r_dev1}, 2'b11);
        check("R4", r_waits == 3, "wait states before early word", r_waits, 3);
        check("R6", r_outcome == 1 && r_word == 32'hA5A5_0001, "delivered word", r_word, 32'hA5A5_0001);

        run_txn(4'b0110, HIT, 16, 32'hB0B0_0016, 0);
        check("R5", r_outcome == 1 && r_waits == 16, "word on 16th wait still delivered", r_waits, 16);

        run_txn(4'b0110, HIT, 0, 32'h0, 0);
        check("R8", r_outcome == 2, "timeout gives retry", r_outcome, 2);
        check("R5", r_waits == 16, "short bound", r_waits, 16);

        run_txn(4'b0110, HIT, 10, 32'hC0C0_0010, 0);
        check("R11", r_outcome == 1 && r_waits == 10, "count restarted after timeout", r_waits, 10);

        lat_sel = 1;
        run_txn(4'b0110, HIT, 0, 32'h0, 0);
        check("R5", r_outcome == 2 && r_waits == 32, "long bound", r_waits, 32);
        run_txn(4'b0110, HIT, 32, 32'hD0D0_0032, 0);
        check("R5", r_outcome == 1 && r_word == 32'hD0D0_0032, "word on 32nd wait delivered", r_outcome, 1);
        lat_sel = 0;

        run_txn(4'b0110, HIT, 2, 32'hE0E0_0002, 3);
        check("R7", r_outcome == 1 && r_word == 32'hE0E0_0002, "late IRDY# completion", r_word, 32'hE0E0_0002);

        run_txn(4'b0110, HIT, 0, 32'h0, 4);
        check("R8", r_outcome == 2 && r_waits == 16, "late FRAME# release after retry", r_outcome, 2);

        run_txn(4'b0110, MISS, 2, 32'h1, 0);
        check("R3", r_outcome == 0 && !r_req_any && !r_req1, "address outside window", r_outcome, 0);
        fifo_empty = 1;
        run_txn(4'b0111, HIT, 2, 32'h1, 0);
        check("R3", r_outcome == 0 && !r_req_any && !r_req1, "non-read command", r_outcome, 0);
        fifo_empty = 1;

        stall_en = 0;
        run_txn(4'b0110, HIT, 1, 32'h1, 0);
        check("R9", r_outcome == 2 && r_waits == 0 && r_req1, "immediate retry mode", r_waits, 0);
        fifo_empty = 1;
        stall_en = 1;

        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog (all requirements) act=%0d exp=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule